// File: doc/BRIEF.md
# Character Display Host Register File

This block is the register file that a host processor sees on an eight-digit, 5x7 dot-matrix character display controller. The host uses an 8-bit data bus, five address lines, an active-low flash-select line and active-low select, write and read strobes. From these the block decodes five storage areas:

- a per-digit character store holding either a 7-bit character code or a user glyph index;
- a one-bit-per-digit flash map;
- a 4-bit glyph pointer;
- a glyph store of 16 user glyphs, each seven rows of five dots;
- an 8-bit control word.

The host strobes are asynchronous. They are brought into the system clock domain through a synchronizer chain, and a write takes effect on the detected rising edge of the write strobe. Readback comes out as a registered data word with a separate output-enable, so pads outside the block can drive the bus. The stored contents are exported continuously to the refresh engine, and a second glyph read port lets the refresh engine fetch dot rows. Reset and the self-clearing clear command each run a short busy window. During that window, and while an external self-test is active, host accesses are dropped.

Top module: `chardisp_hostregs`

## Requirements
- R1: While `rst_n` is low, and for RST_CYCLES clocks after it rises, `busy` and `scan_restart` are high. Reset loads every character cell with 20h and clears the flash map and the control word to 00h.
- R2: A write is committed SYNC_STAGES+1 clocks after `wr_n` rises, and only if `sel_n` was low while `wr_n` was low. A write strobe with `sel_n` held high changes nothing.
- R3: With `fsel_n` low the flash map is the target, whatever `addr[4:3]` holds. `addr[2:0]` picks the digit and only data bit 0 is stored (1 = flash on). A flash read returns the stored bit in bit 0 and zeros in bits 7..1.
- R4: With `fsel_n` high and `addr[4:3]` = 00, the glyph pointer stores data bits 3..0. Data bits 7..4 are ignored, and they read back as zero.
- R5: With `fsel_n` high and `addr[4:3]` = 01, data bits 4..0 are written into row `addr[2:0]` of the glyph the pointer selects. Readback places them in bits 4..0 with zeros above. Row 7 is not a valid row: writes to it are ignored and reads of it return zero.
- R6: With `fsel_n` high and `addr[4:3]` = 11, all eight data bits are stored in digit `addr[2:0]`, where `addr[2]` is the MSB and digit 0 is the leftmost. Digit d is exported on `char_cells[8d+7:8d]`.
- R7: With `fsel_n` high and `addr[4:3]` = 10, the control word is written. Bit 5 is read-only and always shows `selftest_ok`; host writes to bit 5 are ignored.
- R8: Writing the control word with bit 7 set starts a clear. The clear sets every character cell to 20h and the flash map to 0, and keeps `busy` high for CLR_CYCLES clocks. At the end, bit 7 returns to 0 and the other control bits keep their written values.
- R9: While `busy` is high, writes are dropped and reads leave `dout_oe` low. `busy` is high during reset, during a clear, and whenever `tst_active` is high.
- R10: `dout_oe` rises SYNC_STAGES+1 clocks after both `rd_n` and `sel_n` are low, and `dout` then carries the selected contents. When `dout_oe` is low, `dout` is zero.
- R11: `udc_scan_dots` returns, without a clock delay, row `udc_scan_row` of glyph `udc_scan_idx`. It returns zero for row 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| sel_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe, commits on its rise |
| rd_n | input | 1 | Active-low read strobe |
| fsel_n | input | 1 | Active-low flash-map select |
| addr | input | 5 | [2:0] digit/row, [4:3] target mode |
| din | input | 8 | Host write data |
| tst_active | input | 1 | Self-test engine running; blocks access |
| selftest_ok | input | 1 | Self-test result shown in control bit 5 |
| dout | output | 8 | Registered readback data |
| dout_oe | output | 1 | Readback drive enable |
| busy | output | 1 | Reset, clear or self-test in progress |
| scan_restart | output | 1 | Refresh counters held in restart |
| char_cells | output | NDIG*8 | Character cells, digit 0 in the low byte |
| flash_bits | output | NDIG | Flash map, bit d for digit d |
| ctrl_word | output | 8 | Control word, bit 5 from `selftest_ok` |
| udc_scan_idx | input | 4 | Refresh glyph index |
| udc_scan_row | input | 3 | Refresh glyph row |
| udc_scan_dots | output | UDC_COLS | Dots of the addressed glyph row |

## Verification
Each result has its own latency. A write shows on the exported state three clocks after the write strobe rises: two synchronizer stages plus the commit register. Readback is valid three clocks after read and select both fall. A clear runs three clocks after its commit, and busy follows reset release for three clocks. The bench drives on falling edges and waits the stated number of falling edges before it samples. It reads `busy` in the exact cycle a clear commits, and it reads the exported state only once the relevant window has closed.

// File: rtl/crf_pkg.sv
package crf_pkg;

   localparam logic [7:0] BLANK_CODE = 8'h20;

   typedef enum logic [2:0] {
      TGT_FLASH,
      TGT_GPTR,
      TGT_GLYPH,
      TGT_CHAR,
      TGT_CTRL
   } tgt_e;

   typedef struct packed {
      logic       fl_n;
      logic [4:0] addr;
      logic [7:0] data;
   } hbus_t;

   function automatic tgt_e decode_tgt(input logic fl_n, input logic [1:0] mode);
      tgt_e t;
      if (!fl_n) t = TGT_FLASH;
      else begin
         case (mode)
            2'b00:   t = TGT_GPTR;
            2'b01:   t = TGT_GLYPH;
            2'b11:   t = TGT_CHAR;
            default: t = TGT_CTRL;
         endcase
      end
      return t;
   endfunction

endpackage

// File: rtl/crf_hostsync.sv
module crf_hostsync
   import crf_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sel_n,
   input  logic       wr_n,
   input  logic       rd_n,
   input  logic       fsel_n,
   input  logic [4:0] addr,
   input  logic [7:0] din,
   output logic       wr_fire,
   output hbus_t      wr_bus,
   output logic       rd_req,
   output logic       rd_fl_n,
   output logic [4:0] rd_addr
);
   localparam int LAST = SYNC_STAGES - 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("crf_hostsync: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sel_p, wr_p, rd_p;
   hbus_t                  bus_p [SYNC_STAGES];
   logic                   wr_q;
   logic                   cap_valid;
   hbus_t                  cap_bus;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_p <= '1;
         wr_p  <= '1;
         rd_p  <= '1;
         for (int i = 0; i < SYNC_STAGES; i++) bus_p[i] <= '0;
      end else begin
         sel_p    <= {sel_p[SYNC_STAGES-2:0], sel_n};
         wr_p     <= {wr_p[SYNC_STAGES-2:0], wr_n};
         rd_p     <= {rd_p[SYNC_STAGES-2:0], rd_n};
         bus_p[0] <= '{fl_n: fsel_n, addr: addr, data: din};
         for (int i = 1; i < SYNC_STAGES; i++) bus_p[i] <= bus_p[i-1];
      end
   end

   // capture while the synchronized write and select are both active
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q      <= 1'b1;
         cap_valid <= 1'b0;
         cap_bus   <= '0;
      end else begin
         wr_q <= wr_p[LAST];
         if (!wr_p[LAST] && !sel_p[LAST]) begin
            cap_valid <= 1'b1;
            cap_bus   <= bus_p[LAST];
         end else if (wr_fire) begin
            cap_valid <= 1'b0;
         end
      end
   end

   assign wr_fire = wr_p[LAST] && !wr_q && cap_valid;
   assign wr_bus  = cap_bus;
   assign rd_req  = !rd_p[LAST] && !sel_p[LAST];
   assign rd_fl_n = bus_p[LAST].fl_n;
   assign rd_addr = bus_p[LAST].addr;

endmodule

// File: rtl/crf_seq.sv
module crf_seq #(
   parameter int RST_CYCLES = 3,
   parameter int CLR_CYCLES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_start,
   input  logic tst_active,
   output logic busy,
   output logic clearing,
   output logic clr_done,
   output logic scan_restart
);
   localparam int MAXC = (RST_CYCLES > CLR_CYCLES) ? RST_CYCLES : CLR_CYCLES;
   localparam int CW   = $clog2(MAXC + 1);

   generate
      if (RST_CYCLES < 1 || CLR_CYCLES < 1) begin : g_bad_len
         $error("crf_seq: window lengths must be at least 1");
      end
   endgenerate

   logic [CW-1:0] rst_cnt, clr_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_cnt <= CW'(RST_CYCLES);
         clr_cnt <= '0;
      end else begin
         if (rst_cnt != '0) rst_cnt <= rst_cnt - CW'(1);
         if (clr_start)           clr_cnt <= CW'(CLR_CYCLES);
         else if (clr_cnt != '0)  clr_cnt <= clr_cnt - CW'(1);
      end
   end

   assign scan_restart = (rst_cnt != '0);
   assign clearing     = (clr_cnt != '0);
   assign clr_done     = (clr_cnt == CW'(1));
   assign busy         = scan_restart || clearing || tst_active;

endmodule

// File: rtl/crf_glyph_store.sv
module crf_glyph_store #(
   parameter int NUM  = 16,
   parameter int ROWS = 7,
   parameter int COLS = 5
) (
   input  logic            clk,
   input  logic            we,
   input  logic [3:0]      w_idx,
   input  logic [2:0]      w_row,
   input  logic [COLS-1:0] w_dots,
   input  logic [3:0]      a_idx,
   input  logic [2:0]      a_row,
   output logic [COLS-1:0] a_dots,
   input  logic [3:0]      b_idx,
   input  logic [2:0]      b_row,
   output logic [COLS-1:0] b_dots
);
   localparam int DEPTH = NUM * ROWS;
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [COLS-1:0] mem [DEPTH];

   function automatic logic in_range(input logic [3:0] i, input logic [2:0] r);
      return (int'(i) < NUM) && (int'(r) < ROWS);
   endfunction

   function automatic logic [AW-1:0] slot(input logic [3:0] i, input logic [2:0] r);
      int t;
      t = int'(i) * ROWS + int'(r);
      return t[AW-1:0];
   endfunction

   always_ff @(posedge clk) begin
      if (we && in_range(w_idx, w_row)) mem[slot(w_idx, w_row)] <= w_dots;
   end

   assign a_dots = in_range(a_idx, a_row) ? mem[slot(a_idx, a_row)] : '0;
   assign b_dots = in_range(b_idx, b_row) ? mem[slot(b_idx, b_row)] : '0;

endmodule

// File: rtl/chardisp_hostregs.sv
module chardisp_hostregs
   import crf_pkg::*;
#(
   parameter int NDIG        = 8,
   parameter int UDC_NUM     = 16,
   parameter int UDC_ROWS    = 7,
   parameter int UDC_COLS    = 5,
   parameter int SYNC_STAGES = 2,
   parameter int RST_CYCLES  = 3,
   parameter int CLR_CYCLES  = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sel_n,
   input  logic                 wr_n,
   input  logic                 rd_n,
   input  logic                 fsel_n,
   input  logic [4:0]           addr,
   input  logic [7:0]           din,
   input  logic                 tst_active,
   input  logic                 selftest_ok,
   output logic [7:0]           dout,
   output logic                 dout_oe,
   output logic                 busy,
   output logic                 scan_restart,
   output logic [NDIG*8-1:0]    char_cells,
   output logic [NDIG-1:0]      flash_bits,
   output logic [7:0]           ctrl_word,
   input  logic [3:0]           udc_scan_idx,
   input  logic [2:0]           udc_scan_row,
   output logic [UDC_COLS-1:0]  udc_scan_dots
);
   localparam logic [7:0] RO_MASK = 8'h20;

   generate
      if (NDIG < 1 || NDIG > 8) begin : g_bad_ndig
         $error("chardisp_hostregs: NDIG must be 1..8");
      end
      if (UDC_NUM < 1 || UDC_NUM > 16 || UDC_ROWS < 1 || UDC_ROWS > 8) begin : g_bad_udc
         $error("chardisp_hostregs: glyph store size out of range");
      end
      if (UDC_COLS < 1 || UDC_COLS > 8) begin : g_bad_cols
         $error("chardisp_hostregs: UDC_COLS must be 1..8");
      end
   endgenerate

   logic       wr_fire, rd_req, rd_fl_n;
   hbus_t      wr_bus;
   logic [4:0] rd_addr;
   logic       clearing, clr_done;

   crf_hostsync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n), .rd_n(rd_n),
      .fsel_n(fsel_n), .addr(addr), .din(din),
      .wr_fire(wr_fire), .wr_bus(wr_bus),
      .rd_req(rd_req), .rd_fl_n(rd_fl_n), .rd_addr(rd_addr)
   );

   tgt_e       wr_tgt, rd_tgt;
   logic       wr_ok, clr_start;
   logic [2:0] w_dig;

   assign wr_tgt    = decode_tgt(wr_bus.fl_n, wr_bus.addr[4:3]);
   assign rd_tgt    = decode_tgt(rd_fl_n, rd_addr[4:3]);
   assign wr_ok     = wr_fire && !busy;
   assign w_dig     = wr_bus.addr[2:0];
   assign clr_start = wr_ok && (wr_tgt == TGT_CTRL) && wr_bus.data[7];

   crf_seq #(.RST_CYCLES(RST_CYCLES), .CLR_CYCLES(CLR_CYCLES)) u_seq (
      .clk(clk), .rst_n(rst_n), .clr_start(clr_start), .tst_active(tst_active),
      .busy(busy), .clearing(clearing), .clr_done(clr_done),
      .scan_restart(scan_restart)
   );

   logic [7:0]      char_q [NDIG];
   logic [NDIG-1:0] flash_q;
   logic [3:0]      gptr_q;
   logic [7:0]      ctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int d = 0; d < NDIG; d++) char_q[d] <= BLANK_CODE;
         flash_q <= '0;
         gptr_q  <= '0;
         ctrl_q  <= '0;
      end else if (clearing) begin
         for (int d = 0; d < NDIG; d++) char_q[d] <= BLANK_CODE;
         flash_q <= '0;
         if (clr_done) ctrl_q[7] <= 1'b0;
      end else if (wr_ok) begin
         case (wr_tgt)
            TGT_FLASH: if (int'(w_dig) < NDIG) flash_q[w_dig] <= wr_bus.data[0];
            TGT_GPTR:  gptr_q <= wr_bus.data[3:0];
            TGT_CHAR:  if (int'(w_dig) < NDIG) char_q[w_dig] <= wr_bus.data;
            TGT_CTRL:  ctrl_q <= wr_bus.data & ~RO_MASK;
            default:   ;
         endcase
      end
   end

   logic [UDC_COLS-1:0] host_dots;

   crf_glyph_store #(.NUM(UDC_NUM), .ROWS(UDC_ROWS), .COLS(UDC_COLS)) u_glyph (
      .clk(clk),
      .we(wr_ok && (wr_tgt == TGT_GLYPH)),
      .w_idx(gptr_q), .w_row(w_dig), .w_dots(wr_bus.data[UDC_COLS-1:0]),
      .a_idx(gptr_q), .a_row(rd_addr[2:0]), .a_dots(host_dots),
      .b_idx(udc_scan_idx), .b_row(udc_scan_row), .b_dots(udc_scan_dots)
   );

   // readback selection
   logic [7:0] rd_val;
   logic [2:0] r_dig;
   assign r_dig = rd_addr[2:0];

   always_comb begin
      rd_val = '0;
      case (rd_tgt)
         TGT_FLASH: if (int'(r_dig) < NDIG) rd_val = {7'b0, flash_q[r_dig]};
         TGT_GPTR:  rd_val = {4'b0, gptr_q};
         TGT_GLYPH: rd_val = 8'(host_dots);
         TGT_CHAR:  if (int'(r_dig) < NDIG) rd_val = char_q[r_dig];
         TGT_CTRL:  rd_val = ctrl_word;
         default:   rd_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout    <= '0;
         dout_oe <= 1'b0;
      end else begin
         dout_oe <= rd_req && !busy;
         dout    <= (rd_req && !busy) ? rd_val : '0;
      end
   end

   generate
      for (genvar g = 0; g < NDIG; g++) begin : g_cells
         assign char_cells[g*8 +: 8] = char_q[g];
      end
   endgenerate

   assign flash_bits = flash_q;
   assign ctrl_word  = {ctrl_q[7:6], selftest_ok, ctrl_q[4:0]};

endmodule

// File: rtl/crf_checker.sv
module crf_checker #(
   parameter int NDIG = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              scan_restart,
   input logic              dout_oe,
   input logic [7:0]        dout,
   input logic [7:0]        ctrl_word,
   input logic [NDIG-1:0]   flash_bits,
   input logic [NDIG*8-1:0] char_cells
);
   logic all_blank;
   always_comb begin
      all_blank = 1'b1;
      for (int d = 0; d < NDIG; d++)
         if (char_cells[d*8 +: 8] != 8'h20) all_blank = 1'b0;
   end

   assert_restart_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
      scan_restart |-> (busy && flash_bits == '0));

   assert_clear_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_word[7] |-> busy);

   assert_clear_blank_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ctrl_word[7]) |-> (all_blank && flash_bits == '0));

   assert_clear_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ctrl_word[7]) |-> (ctrl_word[6] == $past(ctrl_word[6])
                               && ctrl_word[4:0] == $past(ctrl_word[4:0])));

   assert_busy_no_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy) |-> !dout_oe);

   assert_idle_dout_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !dout_oe |-> (dout == 8'h00));

endmodule

bind chardisp_hostregs crf_checker #(.NDIG(NDIG)) u_crf_checker (
   .clk(clk), .rst_n(rst_n), .busy(busy), .scan_restart(scan_restart),
   .dout_oe(dout_oe), .dout(dout), .ctrl_word(ctrl_word),
   .flash_bits(flash_bits), .char_cells(char_cells)
);

// File: tb/chardisp_hostregs_tb_top.sv
module chardisp_hostregs_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sel_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, fsel_n = 1'b1;
   logic [4:0] addr = '0;
   logic [7:0] din = '0;
   logic       tst_active = 1'b0, selftest_ok = 1'b1;
   logic [7:0] dout;
   logic       dout_oe, busy, scan_restart;
   logic [63:0] char_cells;
   logic [7:0]  flash_bits, ctrl_word;
   logic [3:0]  udc_scan_idx = '0;
   logic [2:0]  udc_scan_row = '0;
   logic [4:0]  udc_scan_dots;

   int  n_tests = 0, n_fail = 0;
   bit  done = 0;
   logic busy_seen;

   always #5 clk = ~clk;

   chardisp_hostregs dut_i (
      .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n), .rd_n(rd_n),
      .fsel_n(fsel_n), .addr(addr), .din(din), .tst_active(tst_active),
      .selftest_ok(selftest_ok), .dout(dout), .dout_oe(dout_oe), .busy(busy),
      .scan_restart(scan_restart), .char_cells(char_cells), .flash_bits(flash_bits),
      .ctrl_word(ctrl_word), .udc_scan_idx(udc_scan_idx), .udc_scan_row(udc_scan_row),
      .udc_scan_dots(udc_scan_dots)
   );

   task automatic chk(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %0h exp %0h", req, what, got, exp);
      end
   endtask

   task automatic bus_wr(input logic fl, input logic [4:0] a, input logic [7:0] d, input logic sel);
      @(negedge clk);
      fsel_n = fl; addr = a; din = d; sel_n = sel; wr_n = 1'b0;
      repeat (3) @(negedge clk);
      wr_n = 1'b1;
      repeat (3) @(negedge clk);
      busy_seen = busy;
      sel_n = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic bus_rd(input logic fl, input logic [4:0] a, output logic [7:0] d, output logic oe);
      @(negedge clk);
      fsel_n = fl; addr = a; sel_n = 1'b0; rd_n = 1'b0;
      repeat (3) @(negedge clk);
      d = dout; oe = dout_oe;
      sel_n = 1'b1; rd_n = 1'b1; fsel_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   function automatic logic [63:0] blanks();
      return {8{8'h20}};
   endfunction

   task automatic t_reset();
      logic [7:0] d; logic oe;
      @(negedge clk); rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "busy just after release", busy, 1'b1);
      chk("R1", "scan_restart just after release", scan_restart, 1'b1);
      chk("R1", "cells blank", char_cells, blanks());
      chk("R1", "flash cleared", flash_bits, 8'h00);
      repeat (5) @(negedge clk);
      chk("R1", "busy ends", busy, 1'b0);
      chk("R1", "scan_restart ends", scan_restart, 1'b0);
      bus_rd(1'b1, 5'b10_000, d, oe);
      chk("R1", "ctrl readback after reset", {oe, d}, {1'b1, 8'h20});
   endtask

   task automatic t_char();
      logic [7:0] d; logic oe;
      bus_wr(1'b1, 5'b11_000, 8'h53, 1'b0);
      bus_wr(1'b1, 5'b11_111, 8'h85, 1'b0);
      chk("R6", "digit0 low byte", char_cells[7:0], 8'h53);
      chk("R6", "digit7 high byte", char_cells[63:56], 8'h85);
      chk("R2", "write lands, others blank", char_cells[55:8], {6{8'h20}});
      bus_rd(1'b1, 5'b11_111, d, oe);
      chk("R10", "char readback", {oe, d}, {1'b1, 8'h85});
   endtask

   task automatic t_nosel();
      bus_wr(1'b1, 5'b11_011, 8'h41, 1'b1);
      chk("R2", "no write without select", char_cells[31:24], 8'h20);
   endtask

   task automatic t_flash();
      logic [7:0] d; logic oe;
      bus_wr(1'b0, 5'b11_010, 8'hFF, 1'b0);
      chk("R3", "flash bit 2 only", flash_bits, 8'h04);
      chk("R3", "mode bits ignored, digit2 char kept", char_cells[23:16], 8'h20);
      bus_rd(1'b0, 5'b01_010, d, oe);
      chk("R3", "flash readback upper zero", {oe, d}, {1'b1, 8'h01});
   endtask

   task automatic t_glyph();
      logic [7:0] d; logic oe;
      logic [4:0] pat [7] = '{5'h0E, 5'h11, 5'h11, 5'h1F, 5'h11, 5'h11, 5'h11};
      bus_wr(1'b1, 5'b00_000, 8'hF5, 1'b0);
      bus_rd(1'b1, 5'b00_000, d, oe);
      chk("R4", "pointer upper bits ignored", {oe, d}, {1'b1, 8'h05});
      for (int r = 0; r < 7; r++) bus_wr(1'b1, {2'b01, 3'(r)}, {3'b111, pat[r]}, 1'b0);
      bus_wr(1'b1, 5'b01_111, 8'h1F, 1'b0);
      udc_scan_idx = 4'd5;
      for (int r = 0; r < 7; r++) begin
         udc_scan_row = 3'(r);
         #1;
         chk("R11", $sformatf("scan row %0d", r), udc_scan_dots, pat[r]);
      end
      udc_scan_row = 3'd7; #1;
      chk("R11", "scan row 7 zero", udc_scan_dots, 5'h00);
      bus_rd(1'b1, 5'b01_011, d, oe);
      chk("R5", "glyph row 3 readback", {oe, d}, {1'b1, 8'h1F});
      bus_rd(1'b1, 5'b01_111, d, oe);
      chk("R5", "row 7 reads zero", {oe, d}, {1'b1, 8'h00});
      bus_rd(1'b1, 5'b01_110, d, oe);
      chk("R5", "row 6 untouched by row 7 write", {oe, d}, {1'b1, 8'h11});
   endtask

   task automatic t_ctrl();
      logic [7:0] d; logic oe;
      selftest_ok = 1'b0;
      bus_wr(1'b1, 5'b10_000, 8'h7B, 1'b0);
      chk("R7", "bit5 not writable", ctrl_word, 8'h5B);
      selftest_ok = 1'b1;
      bus_rd(1'b1, 5'b10_101, d, oe);
      chk("R7", "bit5 shows selftest_ok", {oe, d}, {1'b1, 8'h7B});
   endtask

   task automatic t_clear();
      bus_wr(1'b1, 5'b11_100, 8'h33, 1'b0);
      bus_wr(1'b0, 5'b00_110, 8'h01, 1'b0);
      bus_wr(1'b1, 5'b10_000, 8'hCB, 1'b0);
      chk("R8", "busy at clear commit", busy_seen, 1'b1);
      chk("R8", "cells blank after clear", char_cells, blanks());
      chk("R8", "flash zero after clear", flash_bits, 8'h00);
      chk("R8", "bit7 self-resets, rest kept", ctrl_word, 8'h6B);
      chk("R8", "busy released", busy, 1'b0);
   endtask

   task automatic t_blocked();
      logic [7:0] d; logic oe;
      tst_active = 1'b1;
      bus_wr(1'b1, 5'b11_001, 8'h5A, 1'b0);
      chk("R9", "write dropped during self-test", char_cells[15:8], 8'h20);
      bus_rd(1'b1, 5'b11_001, d, oe);
      chk("R9", "no read drive while busy", {oe, d}, {1'b0, 8'h00});
      tst_active = 1'b0;
      bus_rd(1'b1, 5'b11_001, d, oe);
      chk("R10", "read after busy", {oe, d}, {1'b1, 8'h20});
   endtask

   initial begin
      t_reset();
      t_char();
      t_nosel();
      t_flash();
      t_glyph();
      t_ctrl();
      t_clear();
      t_blocked();
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL R2 watchdog: got hang exp completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule